// File: doc/BRIEF.md
# Time-Shared Dual-Channel Converter Word Receiver

This receiver sits behind a two-channel analog-to-digital converter whose channels share one 10-bit output bus. Both channels are sampled on the same rising edge of the converter clock. The channel A result comes out during the high phase that follows the fifth later rising edge. The channel B result from the same sampling edge follows half a clock cycle later, during the low phase. The receiver latches the bus on both clock edges. It uses the channel indicator, and not the phase a word arrived in, to decide which channel each word belongs to. It joins every A word with the B word that follows it and presents the pair as one record with a single-cycle strobe.

Each record carries the number of the rising edge on which the converter sampled it, so downstream logic can line up pairs with the sampling clock. The receiver can be told that the converter emits offset-binary coding, and in that case it normalizes both words to two's complement. While the converter is powered down, its bus holds a stale value, so every word seen then is discarded. After reset, and again after power-down ends, the words are ignored for the length of the pipeline latency. This keeps any record from carrying an index from before the converter was running.

Top module: `adc_demux_rx`

## Requirements
- R1: While rst_ni is low, and after it is released until the first record, pair_vld_o and orphan_err_o are both 0.
- R2: A word seen with bus_is_a_i=1 is a channel A word and one seen with bus_is_a_i=0 is a channel B word. For a sampling edge k, the A word is on the bus during the high phase after edge k+5 and the B word during the following low phase. pair_vld_o is then high for exactly the one cycle after edge k+7, with chan_a_o and chan_b_o carrying those two words.
- R3: pair_idx_o of a record equals k, its sampling edge, modulo 2^IDX_W. Edge 0 is the first rising edge after rst_ni goes high.
- R4: Words on the bus during the high and low phases after edges 0 to 4 following reset produce no record and no error, whatever their indicator values.
- R5: With twos_mode_i=0 the converter is taken to emit offset binary, and both output words have their most significant bit (bit 9) inverted. With twos_mode_i=1 the words pass through unchanged.
- R6: A B word that arrives with no A word waiting is discarded. It sets orphan_err_o, which then stays 1 until reset.
- R7: When an A word is followed by another A word, the first one is discarded with no error. The second one pairs with the next B word.
- R8: When pwr_dn_i is sampled high at edge p, the words staged at p are discarded and any waiting A word is dropped. When pwr_dn_i is first sampled low again at edge q, words before the high phase after edge q+5 are ignored, as in R4.
- R9: The edge count behind pair_idx_o advances on every rising edge, including edges during power-down. Records after a power-down therefore still carry their true sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock; words are latched on both edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 10 | Shared converter output bus |
| bus_is_a_i | input | 1 | Channel indicator: 1 = channel A word, 0 = channel B word |
| twos_mode_i | input | 1 | Coding used by the converter: 0 = offset binary, 1 = two's complement |
| pwr_dn_i | input | 1 | Converter power-down; bus contents are stale while high |
| pair_vld_o | output | 1 | One-cycle strobe for a new record |
| chan_a_o | output | 10 | Channel A word in two's complement |
| chan_b_o | output | 10 | Channel B word in two's complement |
| pair_idx_o | output | 16 | Sampling edge number of the record |
| orphan_err_o | output | 1 | Sticky flag for a B word that had no A word to pair with |

## Verification
Power-down entry can coincide with the emission of a record. The last pair sampled before power-down reaches the output register on the same edge at which pwr_dn_i is already sampled high, and that edge also clears the waiting A word. The bench raises pwr_dn_i exactly one slot after the last usable bus slot. It then checks that this final record still appears with the right words and index, and that nothing further is emitted until the warm-up after the wake-up edge has passed. The pairing itself is stressed with randomly placed lone-A and orphan-B slots between regular pairs, and each record is checked against values the bench predicts from the sampling edge.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  parameter int DATA_W = 10;

  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic  is_a;
    data_t data;
  } word_t;

  // offset binary -> two's complement: flip the sign bit
  function automatic data_t to_twos(data_t d, logic twos);
    return twos ? d : {~d[DATA_W-1], d[DATA_W-2:0]};
  endfunction
endpackage

// File: rtl/adc_rx_capture.sv
module adc_rx_capture
  import adc_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  data_t bus_data_i,
  input  logic  bus_is_a_i,
  input  logic  accept_i,
  output word_t st_hi_o,
  output word_t st_lo_o,
  output logic  st_ok_o
);
  word_t hi_q;

  // high-phase word, latched on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else         hi_q <= '{is_a: bus_is_a_i, data: bus_data_i};
  end

  // stage both halves of the cycle in the rising-edge domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_hi_o <= '0;
      st_lo_o <= '0;
      st_ok_o <= 1'b0;
    end else begin
      st_hi_o <= hi_q;
      st_lo_o <= '{is_a: bus_is_a_i, data: bus_data_i};
      st_ok_o <= accept_i;
    end
  end
endmodule

// File: rtl/adc_rx_timebase.sv
module adc_rx_timebase #(
  parameter int IDX_W = 16,
  parameter int LAT   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_dn_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int WARM = LAT + 1;
  localparam int WW   = $clog2(WARM + 1);
  localparam int OFS  = LAT + 2;

  logic [IDX_W-1:0] cnt_q;
  logic [WW-1:0]    wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (pwr_dn_i)                 wcnt_q <= '0;
      else if (wcnt_q != WW'(WARM)) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign accept_o = !pwr_dn_i && (wcnt_q == WW'(WARM));
  // record leaves the pairer OFS edges after its sampling edge
  assign idx_o    = cnt_q - IDX_W'(OFS);

  a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cnt_q == IDX_W'($past(cnt_q) + 1'b1));
  a_r8_warm_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WW'(WARM));
  a_r8_pd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> wcnt_q == '0);
endmodule

// File: rtl/adc_rx_pairer.sv
module adc_rx_pairer
  import adc_rx_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  word_t            st_hi_i,
  input  word_t            st_lo_i,
  input  logic             st_ok_i,
  input  logic             twos_mode_i,
  input  logic             pwr_dn_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             pair_vld_o,
  output data_t            chan_a_o,
  output data_t            chan_b_o,
  output logic [IDX_W-1:0] pair_idx_o,
  output logic             orphan_err_o
);
  localparam int SLOTS = 2;

  word_t slot [SLOTS];
  logic  pend_q, pend_d;
  data_t pdat_q, pdat_d;
  logic  emit;
  logic  orphan;
  data_t ea, eb;

  assign slot[0] = st_hi_i;
  assign slot[1] = st_lo_i;

  // words in arrival order: high phase first, then low phase
  always_comb begin
    pend_d = pend_q;
    pdat_d = pdat_q;
    emit   = 1'b0;
    orphan = 1'b0;
    ea     = '0;
    eb     = '0;
    if (st_ok_i) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (slot[i].is_a) begin
          pend_d = 1'b1;
          pdat_d = slot[i].data;
        end else if (pend_d) begin
          emit   = 1'b1;
          ea     = pdat_d;
          eb     = slot[i].data;
          pend_d = 1'b0;
        end else begin
          orphan = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pdat_q       <= '0;
      pair_vld_o   <= 1'b0;
      chan_a_o     <= '0;
      chan_b_o     <= '0;
      pair_idx_o   <= '0;
      orphan_err_o <= 1'b0;
    end else begin
      pend_q       <= pend_d && !pwr_dn_i;
      pdat_q       <= pdat_d;
      pair_vld_o   <= emit;
      orphan_err_o <= orphan_err_o | orphan;
      if (emit) begin
        chan_a_o   <= to_twos(ea, twos_mode_i);
        chan_b_o   <= to_twos(eb, twos_mode_i);
        pair_idx_o <= idx_i;
      end
    end
  end

  a_r4_vld_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> $past(st_ok_i));
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orphan_err_o |=> orphan_err_o);
  a_r6_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(orphan_err_o) |-> $past(st_ok_i));
endmodule

// File: rtl/adc_demux_rx.sv
module adc_demux_rx
  import adc_rx_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int LAT   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic               bus_is_a_i,
  input  logic               twos_mode_i,
  input  logic               pwr_dn_i,
  output logic               pair_vld_o,
  output logic [DATA_W-1:0]  chan_a_o,
  output logic [DATA_W-1:0]  chan_b_o,
  output logic [IDX_W-1:0]   pair_idx_o,
  output logic               orphan_err_o
);
  word_t            st_hi, st_lo;
  logic             st_ok;
  logic             accept;
  logic [IDX_W-1:0] idx;

  adc_rx_timebase #(.IDX_W(IDX_W), .LAT(LAT)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_dn_i (pwr_dn_i),
    .accept_o (accept),
    .idx_o    (idx)
  );

  adc_rx_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_data_i (bus_data_i),
    .bus_is_a_i (bus_is_a_i),
    .accept_i   (accept),
    .st_hi_o    (st_hi),
    .st_lo_o    (st_lo),
    .st_ok_o    (st_ok)
  );

  adc_rx_pairer #(.IDX_W(IDX_W)) u_pair (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_hi_i      (st_hi),
    .st_lo_i      (st_lo),
    .st_ok_i      (st_ok),
    .twos_mode_i  (twos_mode_i),
    .pwr_dn_i     (pwr_dn_i),
    .idx_i        (idx),
    .pair_vld_o   (pair_vld_o),
    .chan_a_o     (chan_a_o),
    .chan_b_o     (chan_b_o),
    .pair_idx_o   (pair_idx_o),
    .orphan_err_o (orphan_err_o)
  );

  a_r8_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> ##1 !pair_vld_o);
  a_r2_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_vld_o |-> $stable(pair_idx_o));
endmodule

// File: tb/sim_adc_demux_rx.sv
`timescale 1ns/1ps
module sim_adc_demux_rx;
  localparam int NE  = 640;
  localparam int PD0 = 320;
  localparam int PDN = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  bus_data_i = '0;
  logic        bus_is_a_i = 1'b0;
  logic        twos_mode_i = 1'b0;
  logic        pwr_dn_i = 1'b0;
  logic        pair_vld_o;
  logic [9:0]  chan_a_o, chan_b_o;
  logic [15:0] pair_idx_o;
  logic        orphan_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit        exp_v   [NE+4];
  int        exp_a   [NE+4];
  int        exp_b   [NE+4];
  int        exp_idx [NE+4];
  string     exp_tag [NE+4];
  int        err_from = 1 << 30;

  always #10 clk_i = ~clk_i;  // 50 MHz

  adc_demux_rx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_data_i(bus_data_i), .bus_is_a_i(bus_is_a_i),
    .twos_mode_i(twos_mode_i), .pwr_dn_i(pwr_dn_i), .pair_vld_o(pair_vld_o),
    .chan_a_o(chan_a_o), .chan_b_o(chan_b_o), .pair_idx_o(pair_idx_o),
    .orphan_err_o(orphan_err_o)
  );

  function automatic int conv(int d, bit t);
    return t ? d : (d ^ 32'h200);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit a, input int d);
    bus_is_a_i = a;
    bus_data_i = d[9:0];
  endtask

  task automatic check_edge(input int e);
    chk(pair_vld_o == exp_v[e], exp_tag[e], "pair_vld_o", int'(pair_vld_o), int'(exp_v[e]));
    if (exp_v[e]) begin
      // R5 coding normalization on both words
      chk(chan_a_o == 10'(conv(exp_a[e], twos_mode_i)), "R5", "chan_a_o",
          int'(chan_a_o), conv(exp_a[e], twos_mode_i));
      chk(chan_b_o == 10'(conv(exp_b[e], twos_mode_i)), "R5", "chan_b_o",
          int'(chan_b_o), conv(exp_b[e], twos_mode_i));
      chk(pair_idx_o == 16'(exp_idx[e]), (e > PD0) ? "R9" : "R3", "pair_idx_o",
          int'(pair_idx_o), exp_idx[e]);
    end
    chk(orphan_err_o == (e >= err_from), "R6", "orphan_err_o",
        int'(orphan_err_o), int'(e >= err_from));
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit pd_drv, pd_at_e, usable, prev_lone;
    int wstart;
    void'($urandom(32'd4711));
    for (int i = 0; i < NE + 4; i++) begin
      exp_v[i] = 0;
      exp_tag[i] = "R2";
    end
    drive(1'b1, 10'h155);
    @(negedge clk_i);
    drive(1'b0, 10'h2aa);
    @(negedge clk_i);
    #1;
    chk(pair_vld_o == 1'b0, "R1", "pair_vld_o in reset", int'(pair_vld_o), 0);
    chk(orphan_err_o == 1'b0, "R1", "orphan_err_o in reset", int'(orphan_err_o), 0);
    #4 rst_ni = 1'b1;
    pd_drv = 0;
    wstart = 0;
    prev_lone = 0;
    for (int e = 0; e < NE; e++) begin
      @(posedge clk_i);
      #1;
      check_edge(e);
      #4;
      pd_at_e = pd_drv;
      if (pd_at_e) wstart = e + 1;
      pd_drv = (e + 1 >= PD0) && (e + 1 < PD0 + PDN);
      pwr_dn_i = pd_drv;
      if (e == PD0 + 4) twos_mode_i = 1'b1;
      usable = !pd_drv && !pd_at_e && (e >= wstart + 5) && (e + 2 < NE);
      if (pd_at_e || pd_drv) begin
        // bus holds its last value during power-down (R8)
        prev_lone = 0;
        if (e + 2 < NE) exp_tag[e+2] = "R8";
        @(negedge clk_i);
        #5;
      end else if (!usable) begin
        // warm-up garbage with random indicators (R4 / R8)
        prev_lone = 0;
        if (e + 2 < NE) exp_tag[e+2] = (wstart > 0) ? "R8" : "R4";
        drive(1'($urandom), int'($urandom));
        @(negedge clk_i);
        #5;
        drive(1'($urandom), int'($urandom));
      end else begin
        int r;
        int da, db;
        r = (e == 40) ? 0 : ((e == 20) ? 1 : int'($urandom % 20));
        da = int'($urandom % 1024);
        db = int'($urandom % 1024);
        if (r == 0 && !prev_lone) begin
          // orphan B: two B words with nothing waiting (R6)
          exp_tag[e+2] = "R6";
          if (err_from > e + 2) err_from = e + 2;
          drive(1'b0, da);
          @(negedge clk_i);
          #5;
          drive(1'b0, db);
          prev_lone = 0;
        end else if (r == 1) begin
          // two A words, no B: no record, no error (R7)
          exp_tag[e+2] = "R7";
          drive(1'b1, da);
          @(negedge clk_i);
          #5;
          drive(1'b1, db);
          prev_lone = 1;
        end else begin
          exp_v[e+2]   = 1;
          exp_a[e+2]   = da;
          exp_b[e+2]   = db;
          exp_idx[e+2] = e - 5;
          exp_tag[e+2] = prev_lone ? "R7" : "R2";
          drive(1'b1, da);
          @(negedge clk_i);
          #5;
          drive(1'b0, db);
          prev_lone = 0;
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule